// File: doc/BRIEF.md
# Timeslot Regulator Power Sequencer

This block drives the enable lines of four supply regulators. A phase machine with five states (OFF, PRE, START, ACTIVE, SHUT) decides who owns those lines. During power-up and power-down the block owns them: it walks through fourteen timeslots and flips each regulator on, or off, in the slot that software gave it. Once in ACTIVE, software owns them through an enable register. Staggering the regulators across slots keeps the in-rush current low.

A small synchronous register port holds four things: the software enable bits, a startup and a shutdown slot code per regulator, and the slot duration. The enable register answers at two addresses that share one set of storage. Enable writes made outside ACTIVE are stored, but they reach the outputs only once ACTIVE is entered. Whenever the startup walk switches a regulator on, it also sets that regulator's software bit, so a read shows the true intent.

Phase transitions:
- OFF→PRE on `wake_req`.
- PRE→START after one cycle.
- START→ACTIVE at the end of slot 14.
- ACTIVE→SHUT on `sleep_req`.
- SHUT→OFF at the end of shutdown slot 14.

Top module: `power_slot_sequencer`

## Requirements
- R1: After reset the block is in OFF with `phase`=0, every `reg_en` bit is low, and the enable register, all slot codes and the slot duration read 0.
- R2: The enable register answers at 0x20 and at 0xA0 with the same storage. Bits [11:8] hold regulators 0..3, and all other bits read 0. A write at one address is seen by a read at the other.
- R3: Regulator i has its slot register at 0x30+i. Bits [3:0] hold the startup code and bits [7:4] the shutdown code. The slot duration register sits at 0x40: a value V makes each slot last V+1 clock cycles.
- R4: `phase` encodes OFF=0, PRE=1, START=2, ACTIVE=3, SHUT=4. In OFF, `wake_req` moves the block to PRE, and PRE always moves to START on the next cycle. `wake_req` has no effect in any other phase.
- R5: In START, a regulator whose startup code is k (1..14) turns on at the end of slot k and stays on. Codes 0 and 15 never turn it on. The block enters ACTIVE at the end of slot 14.
- R6: When the startup walk turns a regulator on, that regulator's enable register bit is set in the same cycle.
- R7: While the phase is OFF, PRE or START, enable register writes are stored but do not change `reg_en`. They take effect on the second cycle of ACTIVE.
- R8: In ACTIVE, `reg_en` equals the enable register bits, one cycle after they change.
- R9: `sleep_req` in ACTIVE moves the block to SHUT. `sleep_req` has no effect in any other phase.
- R10: In SHUT, a regulator whose shutdown code is k (1..14) turns off at the end of shutdown slot k. No regulator turns on during SHUT.
- R11: At the end of shutdown slot 14 the block enters OFF. All `reg_en` bits go low at that point, including those with shutdown code 0 or 15, and all enable register bits are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wake_req | input | 1 | Power-up request, sampled in OFF |
| sleep_req | input | 1 | Power-down request, sampled in ACTIVE |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data (combinational on address) |
| reg_en | output | 4 | Registered regulator enables |
| phase | output | 3 | Current phase code |

## Verification
Some rules are checked by assertions on every cycle:
- OFF and PRE hold every enable low.
- No enable falls during START, and none rises during SHUT.
- In ACTIVE the enables track the register bits with one cycle of delay.
- The slot index stays within 1..14.
- A startup set lands in the register, and entering OFF clears it.

Other behaviour only the bench scenarios can show:
- The exact slot in which each code fires.
- The slot length for each duration value.
- Aliased readback at both addresses.
- Deferred writes surfacing on the second ACTIVE cycle.
- Requests being ignored in the wrong phase.

The bench checks these against a cycle model built from the requirements, under both random and directed configurations.

// File: rtl/pseq_pkg.sv
package pseq_pkg;

    typedef enum logic [2:0] {
        PH_OFF    = 3'd0,
        PH_PRE    = 3'd1,
        PH_START  = 3'd2,
        PH_ACTIVE = 3'd3,
        PH_SHUT   = 3'd4
    } phase_t;

endpackage

// File: rtl/pseq_regs.sv
module pseq_regs #(
    parameter int                  NUM_REG    = 4,
    parameter int                  CODE_W     = 4,
    parameter int                  TICK_W     = 16,
    parameter int                  ADDR_W     = 8,
    parameter int                  DATA_W     = 16,
    parameter int                  ENA_LSB    = 8,
    parameter logic [ADDR_W-1:0]   ENA_ADDR_A = 8'h20,
    parameter logic [ADDR_W-1:0]   ENA_ADDR_B = 8'hA0,
    parameter logic [ADDR_W-1:0]   SLOT_BASE  = 8'h30,
    parameter logic [ADDR_W-1:0]   TICK_ADDR  = 8'h40
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_wr,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [DATA_W-1:0]          bus_wdata,
    output logic [DATA_W-1:0]          bus_rdata,
    input  logic [NUM_REG-1:0]         seq_set,
    input  logic [NUM_REG-1:0]         seq_clr,
    output logic [NUM_REG-1:0]         sw_ena,
    output logic [NUM_REG*CODE_W-1:0]  start_codes,
    output logic [NUM_REG*CODE_W-1:0]  shut_codes,
    output logic [TICK_W-1:0]          tick_iv
);

    logic                      ena_hit;
    logic [NUM_REG-1:0]        sw_d;
    logic [CODE_W-1:0]         start_q [NUM_REG];
    logic [CODE_W-1:0]         shut_q  [NUM_REG];

    assign ena_hit = (bus_addr == ENA_ADDR_A) || (bus_addr == ENA_ADDR_B);

    // The sequencer has the last word over a software write in the same cycle.
    always_comb begin
        sw_d = (bus_wr && ena_hit) ? bus_wdata[ENA_LSB +: NUM_REG] : sw_ena;
        sw_d = (sw_d | seq_set) & ~seq_clr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sw_ena  <= '0;
            tick_iv <= '0;
        end else begin
            sw_ena <= sw_d;
            if (bus_wr && bus_addr == TICK_ADDR)
                tick_iv <= bus_wdata[TICK_W-1:0];
        end
    end

    for (genvar g = 0; g < NUM_REG; g++) begin : g_slot
        localparam logic [ADDR_W-1:0] MY_ADDR = SLOT_BASE + ADDR_W'(g);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                start_q[g] <= '0;
                shut_q[g]  <= '0;
            end else if (bus_wr && bus_addr == MY_ADDR) begin
                start_q[g] <= bus_wdata[CODE_W-1:0];
                shut_q[g]  <= bus_wdata[2*CODE_W-1:CODE_W];
            end
        end

        assign start_codes[g*CODE_W +: CODE_W] = start_q[g];
        assign shut_codes[g*CODE_W +: CODE_W]  = shut_q[g];
    end

    always_comb begin
        bus_rdata = '0;
        if (ena_hit)
            bus_rdata[ENA_LSB +: NUM_REG] = sw_ena;
        if (bus_addr == TICK_ADDR)
            bus_rdata[TICK_W-1:0] = tick_iv;
        for (int i = 0; i < NUM_REG; i++) begin
            if (bus_addr == SLOT_BASE + ADDR_W'(i))
                bus_rdata[2*CODE_W-1:0] = {shut_q[i], start_q[i]};
        end
    end

    AST_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (|seq_set && seq_clr == '0) |=> ((sw_ena & $past(seq_set)) == $past(seq_set))); // R6

    AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (&seq_clr) |=> (sw_ena == '0)); // R11

endmodule

// File: rtl/pseq_slot_timer.sv
module pseq_slot_timer #(
    parameter int TICK_W    = 16,
    parameter int NUM_SLOTS = 14,
    parameter int SLOT_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [TICK_W-1:0] tick_iv,
    output logic              tick,
    output logic [SLOT_W-1:0] slot,
    output logic              last
);

    localparam logic [SLOT_W-1:0] SLOT_FIRST = SLOT_W'(1);
    localparam logic [SLOT_W-1:0] SLOT_FINAL = SLOT_W'(NUM_SLOTS);

    logic [TICK_W-1:0] tcnt;

    // ">=" keeps a shortened duration from letting the counter run past it.
    assign tick = run && (tcnt >= tick_iv);
    assign last = tick && (slot == SLOT_FINAL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt <= '0;
            slot <= SLOT_FIRST;
        end else if (!run) begin
            tcnt <= '0;
            slot <= SLOT_FIRST;
        end else if (tick) begin
            tcnt <= '0;
            slot <= (slot == SLOT_FINAL) ? SLOT_FIRST : slot + SLOT_W'(1);
        end else begin
            tcnt <= tcnt + TICK_W'(1);
        end
    end

    AST_SLOT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (slot >= SLOT_FIRST && slot <= SLOT_FINAL)); // R5

endmodule

// File: rtl/pseq_fsm.sv
module pseq_fsm
    import pseq_pkg::*;
#(
    parameter int NUM_REG = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wake_req,
    input  logic               sleep_req,
    input  logic               tick_last,
    input  logic [NUM_REG-1:0] start_hit,
    input  logic [NUM_REG-1:0] shut_hit,
    input  logic [NUM_REG-1:0] sw_ena,
    output phase_t             phase,
    output logic               run,
    output logic [NUM_REG-1:0] seq_set,
    output logic [NUM_REG-1:0] seq_clr,
    output logic [NUM_REG-1:0] reg_en
);

    phase_t             state_q, state_d;
    logic [NUM_REG-1:0] en_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_OFF:    if (wake_req)  state_d = PH_PRE;
            PH_PRE:                   state_d = PH_START;
            PH_START:  if (tick_last) state_d = PH_ACTIVE;
            PH_ACTIVE: if (sleep_req) state_d = PH_SHUT;
            PH_SHUT:   if (tick_last) state_d = PH_OFF;
            default:                  state_d = PH_OFF;
        endcase
    end

    always_comb begin
        run     = 1'b0;
        seq_set = '0;
        seq_clr = '0;
        en_d    = reg_en;
        unique case (state_q)
            PH_OFF, PH_PRE: en_d = '0;
            PH_START: begin
                run     = 1'b1;
                seq_set = start_hit;
                en_d    = reg_en | start_hit;
            end
            PH_ACTIVE: en_d = sw_ena;
            PH_SHUT: begin
                run     = 1'b1;
                seq_clr = tick_last ? '1 : shut_hit;
                en_d    = tick_last ? '0 : (reg_en & ~shut_hit);
            end
            default: en_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) reg_en <= '0;
        else        reg_en <= en_d;
    end

    assign phase = state_q;

    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_OFF || state_q == PH_PRE) |-> (reg_en == '0)); // R11

    AST_START_NO_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_START && $past(state_q) == PH_START)
            |-> ((reg_en & $past(reg_en)) == $past(reg_en))); // R5

    AST_SHUT_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_SHUT && $past(state_q) == PH_SHUT)
            |-> ((reg_en & ~$past(reg_en)) == '0)); // R10

    AST_ACTIVE_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_ACTIVE && $past(state_q) == PH_ACTIVE)
            |-> (reg_en == $past(sw_ena))); // R8

    AST_OFF_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_OFF && $past(state_q) == PH_SHUT) |-> (sw_ena == '0)); // R11

endmodule

// File: rtl/power_slot_sequencer.sv
module power_slot_sequencer
    import pseq_pkg::*;
#(
    parameter int                NUM_REG    = 4,
    parameter int                NUM_SLOTS  = 14,
    parameter int                CODE_W     = 4,
    parameter int                TICK_W     = 16,
    parameter int                ADDR_W     = 8,
    parameter int                DATA_W     = 16,
    parameter int                ENA_LSB    = 8,
    parameter logic [ADDR_W-1:0] ENA_ADDR_A = 8'h20,
    parameter logic [ADDR_W-1:0] ENA_ADDR_B = 8'hA0,
    parameter logic [ADDR_W-1:0] SLOT_BASE  = 8'h30,
    parameter logic [ADDR_W-1:0] TICK_ADDR  = 8'h40
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wake_req,
    input  logic               sleep_req,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic [NUM_REG-1:0] reg_en,
    output logic [2:0]         phase
);

    localparam int CODES_W = NUM_REG * CODE_W;

    logic [NUM_REG-1:0] sw_ena, seq_set, seq_clr, start_hit, shut_hit;
    logic [CODES_W-1:0] start_codes, shut_codes;
    logic [TICK_W-1:0]  tick_iv;
    logic               run, tick, last;
    logic [CODE_W-1:0]  slot;
    phase_t             phase_w;

    pseq_regs #(
        .NUM_REG(NUM_REG), .CODE_W(CODE_W), .TICK_W(TICK_W), .ADDR_W(ADDR_W),
        .DATA_W(DATA_W), .ENA_LSB(ENA_LSB), .ENA_ADDR_A(ENA_ADDR_A),
        .ENA_ADDR_B(ENA_ADDR_B), .SLOT_BASE(SLOT_BASE), .TICK_ADDR(TICK_ADDR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .seq_set(seq_set),
        .seq_clr(seq_clr), .sw_ena(sw_ena), .start_codes(start_codes),
        .shut_codes(shut_codes), .tick_iv(tick_iv)
    );

    pseq_slot_timer #(
        .TICK_W(TICK_W), .NUM_SLOTS(NUM_SLOTS), .SLOT_W(CODE_W)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .run(run), .tick_iv(tick_iv),
        .tick(tick), .slot(slot), .last(last)
    );

    // Slot indices run 1..NUM_SLOTS, so codes 0 and 15 never match.
    for (genvar g = 0; g < NUM_REG; g++) begin : g_hit
        assign start_hit[g] = tick && (start_codes[g*CODE_W +: CODE_W] == slot);
        assign shut_hit[g]  = tick && (shut_codes[g*CODE_W +: CODE_W]  == slot);
    end

    pseq_fsm #(.NUM_REG(NUM_REG)) u_fsm (
        .clk(clk), .rst_n(rst_n), .wake_req(wake_req), .sleep_req(sleep_req),
        .tick_last(last), .start_hit(start_hit), .shut_hit(shut_hit),
        .sw_ena(sw_ena), .phase(phase_w), .run(run), .seq_set(seq_set),
        .seq_clr(seq_clr), .reg_en(reg_en)
    );

    assign phase = phase_w;

endmodule

// File: tb/tb_power_slot_sequencer.sv
module tb_power_slot_sequencer;

    localparam logic [7:0] A_ENA0 = 8'h20;
    localparam logic [7:0] A_ENA1 = 8'hA0;
    localparam logic [7:0] A_SLOT = 8'h30;
    localparam logic [7:0] A_TICK = 8'h40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wake_req = 1'b0, sleep_req = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic [3:0]  reg_en;
    logic [2:0]  phase;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    power_slot_sequencer dut (
        .clk(clk), .rst_n(rst_n), .wake_req(wake_req), .sleep_req(sleep_req),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .reg_en(reg_en), .phase(phase)
    );

    // Cycle model built from the requirements
    logic [2:0]  m_ph;
    logic [3:0]  m_slot, m_sw, m_en;
    logic [15:0] m_tcnt, m_iv;
    logic [3:0]  m_start [4];
    logic [3:0]  m_shut  [4];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ph <= 3'd0; m_slot <= 4'd1; m_tcnt <= '0; m_iv <= '0;
            m_sw <= '0;   m_en <= '0;
            for (int i = 0; i < 4; i++) begin
                m_start[i] <= '0;
                m_shut[i]  <= '0;
            end
        end else begin
            logic       tk, lst;
            logic [3:0] on_hit, off_hit, swn;
            tk  = (m_ph == 3'd2 || m_ph == 3'd4) && (m_tcnt >= m_iv);
            lst = tk && (m_slot == 4'd14);
            on_hit = '0; off_hit = '0;
            for (int i = 0; i < 4; i++) begin
                on_hit[i]  = tk && (m_start[i] == m_slot);
                off_hit[i] = tk && (m_shut[i]  == m_slot);
            end
            swn = m_sw;
            if (bus_wr && (bus_addr == A_ENA0 || bus_addr == A_ENA1))
                swn = bus_wdata[11:8];
            if (m_ph == 3'd2) swn = swn | on_hit;
            if (m_ph == 3'd4) swn = lst ? 4'd0 : (swn & ~off_hit);
            m_sw <= swn;
            if (bus_wr && bus_addr == A_TICK) m_iv <= bus_wdata;
            for (int i = 0; i < 4; i++) begin
                if (bus_wr && bus_addr == A_SLOT + 8'(i)) begin
                    m_start[i] <= bus_wdata[3:0];
                    m_shut[i]  <= bus_wdata[7:4];
                end
            end
            if (m_ph == 3'd2 || m_ph == 3'd4) begin
                if (tk) begin
                    m_tcnt <= '0;
                    m_slot <= (m_slot == 4'd14) ? 4'd1 : m_slot + 4'd1;
                end else begin
                    m_tcnt <= m_tcnt + 16'd1;
                end
            end else begin
                m_tcnt <= '0; m_slot <= 4'd1;
            end
            case (m_ph)
                3'd0: begin m_en <= '0; if (wake_req) m_ph <= 3'd1; end
                3'd1: begin m_en <= '0; m_ph <= 3'd2; end
                3'd2: begin m_en <= m_en | on_hit; if (lst) m_ph <= 3'd3; end
                3'd3: begin m_en <= m_sw; if (sleep_req) m_ph <= 3'd4; end
                default: begin
                    m_en <= lst ? 4'd0 : (m_en & ~off_hit);
                    if (lst) m_ph <= 3'd0;
                end
            endcase
        end
    end

    function automatic logic [15:0] exp_rd(input logic [7:0] a);
        logic [15:0] r;
        r = '0;
        if (a == A_ENA0 || a == A_ENA1) r[11:8] = m_sw;
        if (a == A_TICK) r = m_iv;
        for (int i = 0; i < 4; i++)
            if (a == A_SLOT + 8'(i)) r = {8'h00, m_shut[i], m_start[i]};
        return r;
    endfunction

    function automatic string en_tag(input logic [2:0] p);
        case (p)
            3'd0:    return "R11";
            3'd1:    return "R7";
            3'd2:    return "R5";
            3'd3:    return "R8";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp, input string what);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Wait for the falling edge, then compare every output with the model.
    task automatic step();
        @(negedge clk);
        if (rst_n) begin
            check(phase == m_ph, "R4", 32'(phase), 32'(m_ph), "phase");
            check(reg_en == m_en, en_tag(m_ph), 32'(reg_en), 32'(m_en), "reg_en");
            check(bus_rdata == exp_rd(bus_addr),
                  (bus_addr == A_ENA0 || bus_addr == A_ENA1) ? "R2" : "R3",
                  32'(bus_rdata), 32'(exp_rd(bus_addr)), "rdata");
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic wait_phase(input logic [2:0] target, input string tag);
        for (int k = 0; k < 300; k++) begin
            if (phase == target) break;
            step();
        end
        check(phase == target, tag, 32'(phase), 32'(target), "phase reached");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL R4 watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        bus_addr = A_ENA0;
        step();
        check(phase == 3'd0, "R1", 32'(phase), 0, "reset phase");
        check(reg_en == 4'd0, "R1", 32'(reg_en), 0, "reset enables");
        check(bus_rdata == 16'h0, "R1", 32'(bus_rdata), 0, "reset enable reg");
        bus_addr = A_SLOT + 8'd2; step();
        check(bus_rdata == 16'h0, "R1", 32'(bus_rdata), 0, "reset slot reg");

        // Alias write at 0xA0, read at 0x20; deferred while OFF
        wr(A_ENA1, 16'h0A00);
        bus_addr = A_ENA0; step();
        check(bus_rdata == 16'h0A00, "R2", 32'(bus_rdata), 32'h0A00, "alias readback");
        check(reg_en == 4'd0, "R7", 32'(reg_en), 0, "write held in OFF");

        wr(A_SLOT + 8'd0, 16'h0031);
        wr(A_SLOT + 8'd1, 16'h000E);
        wr(A_SLOT + 8'd2, 16'h0000);
        wr(A_SLOT + 8'd3, 16'h00EF);
        wr(A_TICK, 16'h0001);
        bus_addr = A_SLOT; step();
        check(bus_rdata == 16'h0031, "R3", 32'(bus_rdata), 32'h31, "slot reg layout");

        // sleep in OFF ignored
        sleep_req = 1'b1; step(); sleep_req = 1'b0; step();
        check(phase == 3'd0, "R9", 32'(phase), 0, "sleep ignored in OFF");

        bus_addr = A_ENA0;
        wake_req = 1'b1; step(); wake_req = 1'b0;
        wait_phase(3'd2, "R4");
        sleep_req = 1'b1; step(); sleep_req = 1'b0;
        wait_phase(3'd3, "R9");
        check(reg_en == 4'b0011, "R5", 32'(reg_en), 32'h3, "startup result");
        check(bus_rdata == 16'h0B00, "R6", 32'(bus_rdata), 32'h0B00, "sequencer sets bits");
        step();
        check(reg_en == 4'b1011, "R7", 32'(reg_en), 32'hB, "deferred write applied");
        wake_req = 1'b1; step(); wake_req = 1'b0;
        check(phase == 3'd3, "R4", 32'(phase), 3, "wake ignored in ACTIVE");
        wr(A_ENA0, 16'h0500); step();
        check(reg_en == 4'b0101, "R8", 32'(reg_en), 32'h5, "active follows write");
        wr(A_ENA1, 16'h0F00); step();
        sleep_req = 1'b1; step(); sleep_req = 1'b0;
        repeat (8) step();
        check(reg_en == 4'b1110, "R10", 32'(reg_en), 32'hE, "shutdown slot 3");
        wait_phase(3'd0, "R11");
        check(reg_en == 4'd0, "R11", 32'(reg_en), 0, "all off in OFF");
        check(bus_rdata == 16'h0, "R11", 32'(bus_rdata), 0, "enable reg cleared");

        // Constrained random traffic
        for (int c = 0; c < 6000; c++) begin
            logic [7:0] pick;
            wake_req  = ($urandom % 25) == 0;
            sleep_req = ($urandom % 40) == 0;
            bus_wr    = ($urandom % 10) == 0;
            pick      = 8'($urandom % 8);
            case (pick)
                8'd0: bus_addr = A_ENA0;
                8'd1: bus_addr = A_ENA1;
                8'd2: bus_addr = A_TICK;
                8'd3: bus_addr = 8'h00;
                default: bus_addr = A_SLOT + (pick - 8'd4);
            endcase
            bus_wdata = 16'($urandom);
            if (bus_addr == A_TICK) bus_wdata = 16'($urandom % 3);
            step();
        end
        bus_wr = 1'b0; wake_req = 1'b0; sleep_req = 1'b0;
        step();

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule